// File: doc/BRIEF.md
# Banked Floating-Point Register File

This block stores the floating-point registers of a processor datapath: 32 physical 32-bit words split into two banks of 16. A bank-select mode bit decides which bank is the front bank, the one that ordinary single, pair and vector accesses reach. The other bank is the back bank. It is reached through an extended single view, or through a pair index with its low bit set. The front bank begins at physical word 16 times the bank-select bit. The back bank begins at 16 times its inverse.

Each of the two write ports and two read ports carries an access kind and a 4-bit logical index. So one port can move one word, an aligned pair of words or a four-word vector. A 32-bit status/control word holds the precision, transfer-size and bank-select bits. Two commands toggle the bank-select and transfer-size bits. A register-to-register move command copies one word, or one pair when the transfer-size bit is set. Arithmetic is done elsewhere.

Every write, move and mode change takes effect at the next rising clock edge. Reads are combinational and use the mode bits that are in force before that edge.

Top module: `fpbank_regfile`

## Requirements
- R1: After a synchronous active-low reset every physical word reads 0, the status/control word reads 0, and all three mode bits are 0.
- R2: Kind code 0 (single) with index i reaches physical word 16*bank + i. The word sits on data bits [31:0].
- R3: Kind code 1 (extended single) with index i reaches physical word 16*(1-bank) + i.
- R4: Kind code 2 (pair) with an even index i reaches physical words 16*bank+i (bits [31:0]) and +i+1 (bits [63:32]). With an odd index it reaches the back-bank pair starting at 16*(1-bank) + (i with bit 0 cleared).
- R5: Kind code 3 (vector) reaches the four front-bank words starting at 16*bank + 4*(i/4), lanes on bits [31:0], [63:32], [95:64] and [127:96]. Index bits 1:0 have no effect.
- R6: Writing the status/control word stores all 32 bits, and those bits read back unchanged. The precision bit is bit 19, the transfer-size bit is bit 20 and the bank-select bit is bit 21.
- R7: The bank toggle command inverts bit 21 and the size toggle command inverts bit 20. A status/control write in the same cycle overrides both commands.
- R8: With the transfer-size bit clear, a move copies the single front-bank word at the source index to the front-bank word at the destination index.
- R9: With the transfer-size bit set, a move copies a 64-bit pair. Source and destination are each mapped as in R4, so an odd index selects a back-bank pair.
- R10: When several writers hit the same physical word in one cycle, write port 0 wins over write port 1, and write port 1 wins over a move.
- R11: Read lanes beyond the width of the access kind return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| w0_en | input | 1 | Write port 0 enable |
| w0_kind | input | 2 | Write port 0 access kind |
| w0_idx | input | 4 | Write port 0 logical index |
| w0_data | input | 128 | Write port 0 data, lane 0 in the low bits |
| w1_en | input | 1 | Write port 1 enable |
| w1_kind | input | 2 | Write port 1 access kind |
| w1_idx | input | 4 | Write port 1 logical index |
| w1_data | input | 128 | Write port 1 data |
| r0_kind | input | 2 | Read port 0 access kind |
| r0_idx | input | 4 | Read port 0 logical index |
| r0_data | output | 128 | Read port 0 data |
| r1_kind | input | 2 | Read port 1 access kind |
| r1_idx | input | 4 | Read port 1 logical index |
| r1_data | output | 128 | Read port 1 data |
| mv_en | input | 1 | Register-to-register move command |
| mv_src | input | 4 | Move source index |
| mv_dst | input | 4 | Move destination index |
| ctl_wr_en | input | 1 | Status/control word write enable |
| ctl_wr_data | input | 32 | Status/control word write value |
| ctl_rdata | output | 32 | Status/control word contents |
| tog_bank | input | 1 | Invert the bank-select bit |
| tog_size | input | 1 | Invert the transfer-size bit |
| mode_bank | output | 1 | Current bank-select bit |
| mode_size | output | 1 | Current transfer-size bit |
| mode_prec | output | 1 | Current precision bit |

## Verification
Some properties are checked on every cycle. The status word takes a written value. Each toggle command flips exactly its own bit. Write port 0 always lands its lane in any physical word it hits, whatever the other writers do. Read lanes outside a single access stay zero. The address mapping can only be shown by the bench's scenarios. These cover the front/back swap after a bank toggle, odd pair indices landing in the back bank, vector alignment, and moves in both transfer sizes. They write through one view and read back through another.

// File: rtl/fpbank_pkg.sv
// Shared sizes, access-kind encoding and status-word bit positions for the
// banked floating-point register file. Assumes two equal banks.
package fpbank_pkg;
    parameter int unsigned WORD_W     = 32;
    parameter int unsigned BANK_WORDS = 16;
    parameter int unsigned LANES      = 4;
    parameter int unsigned CTL_W      = 32;
    parameter int unsigned PREC_POS   = 19;
    parameter int unsigned SIZE_POS   = 20;
    parameter int unsigned BANK_POS   = 21;

    localparam int unsigned PHYS_WORDS = 2 * BANK_WORDS;
    localparam int unsigned IDX_W      = $clog2(BANK_WORDS);
    localparam int unsigned PHYS_W     = $clog2(PHYS_WORDS);
    localparam int unsigned LANE_IDX_W = $clog2(LANES);
    localparam int unsigned DATA_W     = WORD_W * LANES;

    typedef enum logic [1:0] {
        ACC_SINGLE = 2'd0,
        ACC_EXT    = 2'd1,
        ACC_PAIR   = 2'd2,
        ACC_VEC    = 2'd3
    } acc_kind_e;
endpackage

// File: rtl/fpbank_map.sv
// Translates an access kind and logical index into a physical base word and
// a lane mask. Purely combinational; assumes power-of-two bank size.
module fpbank_map
    import fpbank_pkg::*;
(
    input  logic                  bank,
    input  logic [1:0]            kind,
    input  logic [IDX_W-1:0]      idx,
    output logic [PHYS_W-1:0]     base,
    output logic [LANES-1:0]      mask
);
    // Select bank half and in-bank offset per access kind.
    always_comb begin
        unique case (acc_kind_e'(kind))
            ACC_SINGLE: begin
                base = {bank, idx};
                mask = LANES'(1);
            end
            ACC_EXT: begin
                base = {~bank, idx};
                mask = LANES'(1);
            end
            ACC_PAIR: begin
                base = {bank ^ idx[0], idx[IDX_W-1:1], 1'b0};
                mask = LANES'(3);
            end
            default: begin
                base = {bank, idx[IDX_W-1:LANE_IDX_W], {LANE_IDX_W{1'b0}}};
                mask = {LANES{1'b1}};
            end
        endcase
    end
endmodule

// File: rtl/fpbank_ctl.sv
// Status/control word holding precision, transfer-size and bank-select bits.
// A full write overrides the toggle commands issued in the same cycle.
module fpbank_ctl
    import fpbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTL_W-1:0]  wr_data,
    input  logic              tog_bank,
    input  logic              tog_size,
    output logic [CTL_W-1:0]  word
);
    logic [CTL_W-1:0] nxt;

    // Next value: full write, else apply any toggles.
    always_comb begin
        nxt = word;
        if (wr_en) begin
            nxt = wr_data;
        end else begin
            if (tog_bank) nxt[BANK_POS] = ~word[BANK_POS];
            if (tog_size) nxt[SIZE_POS] = ~word[SIZE_POS];
        end
    end

    // Register the status word.
    always_ff @(posedge clk) begin
        if (!rst_n) word <= '0;
        else        word <= nxt;
    end

    p_ctl_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> word == $past(wr_data));
    p_bank_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && tog_bank) |=> word[BANK_POS] != $past(word[BANK_POS]));
    p_size_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && tog_size) |=> word[SIZE_POS] != $past(word[SIZE_POS]));
endmodule

// File: rtl/fpbank_store.sv
// Physical word storage with NW prioritised writers (index 0 highest) and NR
// combinational readers. Each access is a base word plus lane mask; lanes
// outside the mask read as zero.
module fpbank_store
    import fpbank_pkg::*;
#(
    parameter int unsigned NW = 3,
    parameter int unsigned NR = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              w_en   [NW],
    input  logic [PHYS_W-1:0] w_base [NW],
    input  logic [LANES-1:0]  w_mask [NW],
    input  logic [DATA_W-1:0] w_data [NW],
    input  logic [PHYS_W-1:0] r_base [NR],
    input  logic [LANES-1:0]  r_mask [NR],
    output logic [DATA_W-1:0] r_data [NR]
);
    logic [WORD_W-1:0] regs [PHYS_WORDS];

    for (genvar p = 0; p < PHYS_WORDS; p++) begin : g_word
        logic [PHYS_W-1:0] off      [NW];
        logic [WORD_W-1:0] lane_val [NW];
        logic [NW-1:0]     hit;
        logic [WORD_W-1:0] nxt;

        // Find which writers cover this word and which lane they supply.
        always_comb begin
            for (int w = 0; w < NW; w++) begin
                off[w]      = PHYS_W'(p) - w_base[w];
                hit[w]      = w_en[w] && (off[w] < PHYS_W'(LANES))
                              && w_mask[w][off[w][LANE_IDX_W-1:0]];
                lane_val[w] = w_data[w][off[w][LANE_IDX_W-1:0]*WORD_W +: WORD_W];
            end
        end

        // Lowest-numbered writer applied last so it wins.
        always_comb begin
            nxt = regs[p];
            for (int w = NW - 1; w >= 0; w--) begin
                if (hit[w]) nxt = lane_val[w];
            end
        end

        // Register the word.
        always_ff @(posedge clk) begin
            if (!rst_n) regs[p] <= '0;
            else        regs[p] <= nxt;
        end

        p_port0_priority_r10: assert property (@(posedge clk) disable iff (!rst_n)
            hit[0] |=> regs[p] == $past(lane_val[0]));
    end

    for (genvar r = 0; r < NR; r++) begin : g_rd
        for (genvar j = 0; j < LANES; j++) begin : g_lane
            logic [PHYS_W-1:0] addr;
            // Fetch one lane of one reader, zero outside the mask.
            always_comb begin
                addr = r_base[r] + PHYS_W'(j);
                r_data[r][j*WORD_W +: WORD_W] = r_mask[r][j] ? regs[addr] : '0;
            end
        end
    end
endmodule

// File: rtl/fpbank_regfile.sv
// Top of the banked floating-point register file. Maps two write ports, two
// read ports and a move command onto physical storage using the current mode
// bits; mode changes apply from the next cycle.
module fpbank_regfile
    import fpbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              w0_en,
    input  logic [1:0]        w0_kind,
    input  logic [IDX_W-1:0]  w0_idx,
    input  logic [DATA_W-1:0] w0_data,
    input  logic              w1_en,
    input  logic [1:0]        w1_kind,
    input  logic [IDX_W-1:0]  w1_idx,
    input  logic [DATA_W-1:0] w1_data,
    input  logic [1:0]        r0_kind,
    input  logic [IDX_W-1:0]  r0_idx,
    output logic [DATA_W-1:0] r0_data,
    input  logic [1:0]        r1_kind,
    input  logic [IDX_W-1:0]  r1_idx,
    output logic [DATA_W-1:0] r1_data,
    input  logic              mv_en,
    input  logic [IDX_W-1:0]  mv_src,
    input  logic [IDX_W-1:0]  mv_dst,
    input  logic              ctl_wr_en,
    input  logic [CTL_W-1:0]  ctl_wr_data,
    output logic [CTL_W-1:0]  ctl_rdata,
    input  logic              tog_bank,
    input  logic              tog_size,
    output logic              mode_bank,
    output logic              mode_size,
    output logic              mode_prec
);
    localparam int unsigned NMAP = 6;  // w0, w1, move dst, r0, r1, move src
    localparam int unsigned NW   = 3;
    localparam int unsigned NR   = 3;

    logic [CTL_W-1:0]  ctl_word;
    logic [1:0]        mv_kind;
    logic [1:0]        m_kind [NMAP];
    logic [IDX_W-1:0]  m_idx  [NMAP];
    logic [PHYS_W-1:0] m_base [NMAP];
    logic [LANES-1:0]  m_mask [NMAP];
    logic              s_wen  [NW];
    logic [DATA_W-1:0] s_wdat [NW];
    logic [PHYS_W-1:0] s_wbas [NW];
    logic [LANES-1:0]  s_wmsk [NW];
    logic [PHYS_W-1:0] s_rbas [NR];
    logic [LANES-1:0]  s_rmsk [NR];
    logic [DATA_W-1:0] s_rdat [NR];

    fpbank_ctl u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ctl_wr_en),
        .wr_data  (ctl_wr_data),
        .tog_bank (tog_bank),
        .tog_size (tog_size),
        .word     (ctl_word)
    );

    // Expose the status word and its mode bits.
    always_comb begin
        ctl_rdata = ctl_word;
        mode_bank = ctl_word[BANK_POS];
        mode_size = ctl_word[SIZE_POS];
        mode_prec = ctl_word[PREC_POS];
    end

    // Collect kind/index of every address map; moves use pair kind in 64-bit size.
    always_comb begin
        mv_kind   = mode_size ? ACC_PAIR : ACC_SINGLE;
        m_kind[0] = w0_kind;  m_idx[0] = w0_idx;
        m_kind[1] = w1_kind;  m_idx[1] = w1_idx;
        m_kind[2] = mv_kind;  m_idx[2] = mv_dst;
        m_kind[3] = r0_kind;  m_idx[3] = r0_idx;
        m_kind[4] = r1_kind;  m_idx[4] = r1_idx;
        m_kind[5] = mv_kind;  m_idx[5] = mv_src;
    end

    for (genvar k = 0; k < NMAP; k++) begin : g_map
        fpbank_map u_map (
            .bank (mode_bank),
            .kind (m_kind[k]),
            .idx  (m_idx[k]),
            .base (m_base[k]),
            .mask (m_mask[k])
        );
    end

    // Route writers (priority order) and readers to storage.
    always_comb begin
        s_wen[0] = w0_en;  s_wdat[0] = w0_data;
        s_wen[1] = w1_en;  s_wdat[1] = w1_data;
        s_wen[2] = mv_en;  s_wdat[2] = s_rdat[2];
        for (int w = 0; w < NW; w++) begin
            s_wbas[w] = m_base[w];
            s_wmsk[w] = m_mask[w];
        end
        for (int r = 0; r < NR; r++) begin
            s_rbas[r] = m_base[NW + r];
            s_rmsk[r] = m_mask[NW + r];
        end
        r0_data = s_rdat[0];
        r1_data = s_rdat[1];
    end

    fpbank_store #(.NW(NW), .NR(NR)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .w_en   (s_wen),
        .w_base (s_wbas),
        .w_mask (s_wmsk),
        .w_data (s_wdat),
        .r_base (s_rbas),
        .r_mask (s_rmsk),
        .r_data (s_rdat)
    );

    p_single_upper_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (r0_kind == 2'd0) |-> r0_data[DATA_W-1:WORD_W] == '0);
endmodule

// File: tb/sim_fpbank_regfile.sv
module sim_fpbank_regfile;
    import fpbank_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic w0_en = 0, w1_en = 0, mv_en = 0, ctl_wr_en = 0, tog_bank = 0, tog_size = 0;
    logic [1:0] w0_kind = 0, w1_kind = 0, r0_kind = 0, r1_kind = 0;
    logic [3:0] w0_idx = 0, w1_idx = 0, r0_idx = 0, r1_idx = 0, mv_src = 0, mv_dst = 0;
    logic [127:0] w0_data = 0, w1_data = 0, r0_data, r1_data;
    logic [31:0] ctl_wr_data = 0, ctl_rdata;
    logic mode_bank, mode_size, mode_prec;
    int checks = 0, errors = 0;

    always #4 clk = ~clk;

    fpbank_regfile u0 (.*);

    task automatic chk(input string tag, input logic [127:0] got, input logic [127:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr0(input logic [1:0] k, input logic [3:0] i, input logic [127:0] d);
        w0_en = 1; w0_kind = k; w0_idx = i; w0_data = d;
        tick();
        w0_en = 0;
    endtask

    task automatic rd(input logic [1:0] k, input logic [3:0] i, output logic [127:0] d);
        r0_kind = k; r0_idx = i;
        #1 d = r0_data;
    endtask

    task automatic tbank(); tog_bank = 1; tick(); tog_bank = 0; endtask
    task automatic tsize(); tog_size = 1; tick(); tog_size = 0; endtask

    task automatic t_reset();
        logic [127:0] d;
        chk("R1 ctl", {96'd0, ctl_rdata}, 0);
        chk("R1 modes", {125'd0, mode_bank, mode_size, mode_prec}, 0);
        for (int i = 0; i < 16; i++) begin
            rd(2'd0, 4'(i), d); chk("R1 front", d, 0);
            rd(2'd1, 4'(i), d); chk("R1 back", d, 0);
        end
    endtask

    task automatic t_single();
        logic [127:0] d;
        wr0(2'd0, 4'd5, 128'h1111_aaaa);
        rd(2'd0, 4'd5, d); chk("R2 front write", d, 128'h1111_aaaa);
        rd(2'd1, 4'd5, d); chk("R3 back empty", d, 0);
        tbank();
        chk("R7 bank toggled", {96'd0, ctl_rdata}, 128'h0020_0000);
        rd(2'd1, 4'd5, d); chk("R3 ext after swap", d, 128'h1111_aaaa);
        rd(2'd0, 4'd5, d); chk("R2 front after swap", d, 0);
        wr0(2'd1, 4'd3, 128'h2222_bbbb);
        tbank();
        rd(2'd0, 4'd3, d); chk("R3 ext write lands low bank", d, 128'h2222_bbbb);
    endtask

    task automatic t_pair_vec();
        logic [127:0] d;
        wr0(2'd2, 4'd4, {64'd0, 32'h4444_0005, 32'h4444_0004});
        rd(2'd0, 4'd4, d); chk("R4 pair low", d, 128'h4444_0004);
        rd(2'd0, 4'd5, d); chk("R4 pair high", d, 128'h4444_0005);
        wr0(2'd2, 4'd7, {64'd0, 32'h7777_0007, 32'h7777_0006});
        rd(2'd1, 4'd6, d); chk("R4 odd pair back low", d, 128'h7777_0006);
        rd(2'd1, 4'd7, d); chk("R4 odd pair back high", d, 128'h7777_0007);
        rd(2'd2, 4'd6, d); chk("R4 front pair untouched", d, 0);
        wr0(2'd3, 4'd9, {32'h9, 32'h8, 32'h7, 32'h6});
        rd(2'd0, 4'd8, d); chk("R5 vec lane0 R11", d, 128'h6);
        rd(2'd0, 4'd11, d); chk("R5 vec lane3", d, 128'h9);
        rd(2'd3, 4'd10, d); chk("R5 vec read", d, {32'h9, 32'h8, 32'h7, 32'h6});
        rd(2'd2, 4'd8, d); chk("R11 pair upper zero", d, {64'd0, 32'h7, 32'h6});
    endtask

    task automatic t_ctl();
        ctl_wr_en = 1; ctl_wr_data = 32'h0028_00a5; tick(); ctl_wr_en = 0;
        chk("R6 readback", {96'd0, ctl_rdata}, 128'h0028_00a5);
        chk("R6 modes", {125'd0, mode_bank, mode_size, mode_prec}, 128'b101);
        tsize();
        chk("R7 size toggle", {96'd0, ctl_rdata}, 128'h0038_00a5);
        ctl_wr_en = 1; ctl_wr_data = 0; tog_bank = 1; tog_size = 1; tick();
        ctl_wr_en = 0; tog_bank = 0; tog_size = 0;
        chk("R7 write overrides toggles", {96'd0, ctl_rdata}, 0);
    endtask

    task automatic t_move();
        logic [127:0] d;
        mv_en = 1; mv_src = 4'd4; mv_dst = 4'd12; tick(); mv_en = 0;
        rd(2'd0, 4'd12, d); chk("R8 single move", d, 128'h4444_0004);
        rd(2'd0, 4'd13, d); chk("R8 neighbour untouched", d, 0);
        tsize();
        mv_en = 1; mv_src = 4'd4; mv_dst = 4'd9; tick(); mv_en = 0;
        rd(2'd1, 4'd8, d); chk("R9 pair to back low", d, 128'h4444_0004);
        rd(2'd1, 4'd9, d); chk("R9 pair to back high", d, 128'h4444_0005);
        mv_en = 1; mv_src = 4'd7; mv_dst = 4'd0; tick(); mv_en = 0;
        rd(2'd0, 4'd0, d); chk("R9 back pair to front low", d, 128'h7777_0006);
        rd(2'd0, 4'd1, d); chk("R9 back pair to front high", d, 128'h7777_0007);
        tsize();
    endtask

    task automatic t_priority();
        logic [127:0] d;
        w0_en = 1; w0_kind = 0; w0_idx = 2; w0_data = 128'hc0;
        w1_en = 1; w1_kind = 0; w1_idx = 2; w1_data = 128'hc1;
        tick(); w0_en = 0; w1_en = 0;
        rd(2'd0, 4'd2, d); chk("R10 port0 wins", d, 128'hc0);
        w1_en = 1; w1_kind = 0; w1_idx = 13; w1_data = 128'hd1;
        mv_en = 1; mv_src = 4; mv_dst = 13;
        tick(); w1_en = 0; mv_en = 0;
        rd(2'd0, 4'd13, d); chk("R10 port1 beats move", d, 128'hd1);
        r1_kind = 2'd0; r1_idx = 4'd2;
        #1 chk("R10 read port1 agrees", r1_data, 128'hc0);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        t_reset();
        t_single();
        t_pair_vec();
        t_ctl();
        t_move();
        t_priority();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule